// File: doc/BRIEF.md
# Quad Prescaled Pulse-Width Modulator

This block drives four pulse-width modulated outputs. Each channel has its own cycle length, set by two cascaded 16-bit dividers. A prescaler turns the input clock into ticks. A period divider counts those ticks to mark out one output cycle. A 16-bit high-time count then sets how many ticks at the start of each cycle the output is held high. Software sets up each channel through a small 32-bit register bus, with one write strobe and a read path that decodes the address combinationally.

Configuration writes go into holding registers and do not disturb a running waveform. A channel picks up new values only when software raises that channel's update request. A running channel applies the request at the end of its current cycle, so no cycle is ever cut short. A stopped channel applies it at once. Software works out the divider pair for a given frequency; the block only counts.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every output is low and every mapped register reads zero.
- R2: Channel c has a timing word at byte offset 8·c and a control word at 8·c+4. The timing word holds the period divider in bits 15:0 and the high-time count in bits 31:16. The control word holds the prescaler in bits 15:0, the update request in bit 30 and the run enable in bit 31. Reads return the stored fields; control-word bits 29:16 read zero.
- R3: While running, an output cycle lasts (prescaler+1)·(period divider+1) clock cycles.
- R4: Each output cycle begins high and stays high for high-time·(prescaler+1) clock cycles, then stays low until the next cycle starts.
- R5: A high-time of zero keeps the output low. A high-time of period divider+1 or more keeps it high.
- R6: Writes change only the holding registers. A running channel keeps its old timing until the end of the cycle that follows an update request, and then switches.
- R7: The update bit reads 1 while a request is pending. On a stopped channel the copy happens on the clock edge after the request becomes visible, and the bit then reads 0. Writing 0 to the update bit does not cancel a pending request.
- R8: When enable is cleared, the output goes low two edges after the write edge, and the counters are held at zero. When a stopped channel is written with enable and update set, its output is low in the cycle after the write and starts a fresh cycle (high when high-time is nonzero) one cycle later.
- R9: Each channel's waveform depends only on its own registers.
- R10: Writes to byte offsets at or above 8·(channel count) change nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counters and registers |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 6 | Byte address, word aligned (bits 1:0 ignored) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| pwmOut | output | 4 | One modulated output per channel |

## Verification
Read data is combinational, so the bench samples it 1 ns after it sets the address, between clock edges. The update bit is read in the cycle after its write edge and is expected high. On a stopped channel it is read again one cycle later and is expected low. Enable and disable are checked over exactly two falling-edge samples after the write edge, which matches the two register stages (control word, then running flag). Waveform timing is measured on falling edges only after any pending request has cleared. The measurement locks onto a rising output sample, counts high samples over one computed cycle length, and expects the following sample to be high again; outputs that are always high or always low are counted over two full cycles.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int BUS_W   = 32;
  localparam int HI_LSB  = 16;
  localparam int UPD_BIT = 30;
  localparam int EN_BIT  = 31;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic run;   // channel enable as stored in the control word
    logic load;  // copy holding registers into active registers
  } chStrobe_t;
endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [BUS_W-1:0]                 wrData,
  output logic [BUS_W-1:0]                 rdData,
  input  logic [NUM_CH-1:0]                periodEnd,
  input  logic [NUM_CH-1:0]                runState,
  output chStrobe_t [NUM_CH-1:0]           strobes,
  output logic [NUM_CH-1:0][CNT_W-1:0]     shPre,
  output logic [NUM_CH-1:0][CNT_W-1:0]     shPer,
  output logic [NUM_CH-1:0][CNT_W-1:0]     shHi,
  output logic [NUM_CH-1:0]                enVec,
  output logic [NUM_CH-1:0]                pendVec
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [WORD_W-1:0] wordIdx;
  logic [CH_W-1:0]   chIdx;
  logic              regSel;
  logic              hit;
  logic [1:0]        unusedByteBits;

  assign wordIdx        = addr[ADDR_W-1:2];
  assign unusedByteBits = addr[1:0];
  assign chIdx          = wordIdx[CH_W:1];
  assign regSel         = wordIdx[0];
  assign hit            = (wordIdx < WORD_W'(2 * NUM_CH));

  logic [NUM_CH-1:0][BUS_W-1:0] word0;
  logic [NUM_CH-1:0][BUS_W-1:0] word1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CNT_W-1:0] preQ, perQ, hiQ;
    logic             enQ, pendQ;
    logic             wrTiming, wrCtrl, loadNow;

    assign wrTiming = wrEn && hit && (chIdx == CH_W'(i)) && !regSel;
    assign wrCtrl   = wrEn && hit && (chIdx == CH_W'(i)) &&  regSel;
    // stopped channel copies at once, running one waits for its cycle end
    assign loadNow  = pendQ && (!runState[i] || periodEnd[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        preQ  <= '0;
        perQ  <= '0;
        hiQ   <= '0;
        enQ   <= 1'b0;
        pendQ <= 1'b0;
      end else begin
        if (wrTiming) begin
          perQ <= wrData[CNT_W-1:0];
          hiQ  <= wrData[HI_LSB +: CNT_W];
        end
        if (wrCtrl) begin
          preQ <= wrData[CNT_W-1:0];
          enQ  <= wrData[EN_BIT];
        end
        if (wrCtrl && wrData[UPD_BIT]) pendQ <= 1'b1;
        else if (loadNow)              pendQ <= 1'b0;
      end
    end

    always_comb begin
      word0[i] = '0;
      word0[i][CNT_W-1:0]      = perQ;
      word0[i][HI_LSB +: CNT_W] = hiQ;
      word1[i] = '0;
      word1[i][CNT_W-1:0]      = preQ;
      word1[i][UPD_BIT]        = pendQ;
      word1[i][EN_BIT]         = enQ;
    end

    assign strobes[i] = '{run: enQ, load: loadNow};
    assign shPre[i]   = preQ;
    assign shPer[i]   = perQ;
    assign shHi[i]    = hiQ;
    assign enVec[i]   = enQ;
    assign pendVec[i] = pendQ;
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (hit && (chIdx == CH_W'(k))) rdData = regSel ? word1[k] : word0[k];
    end
  end
endmodule

// File: rtl/pwm_quad_dp.sv
module pwm_quad_dp
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  chStrobe_t [NUM_CH-1:0]       strobes,
  input  logic [NUM_CH-1:0][CNT_W-1:0] shPre,
  input  logic [NUM_CH-1:0][CNT_W-1:0] shPer,
  input  logic [NUM_CH-1:0][CNT_W-1:0] shHi,
  output logic [NUM_CH-1:0]            pwmOut,
  output logic [NUM_CH-1:0]            periodEnd,
  output logic [NUM_CH-1:0]            runState,
  output logic [NUM_CH-1:0]            startVec
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CNT_W-1:0] actPre, actPer, actHi;
    logic [CNT_W-1:0] tickCnt, stepCnt;
    logic             runQ;
    logic             tickWrap;

    assign tickWrap = (tickCnt == actPre);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actPre  <= '0;
        actPer  <= '0;
        actHi   <= '0;
        tickCnt <= '0;
        stepCnt <= '0;
        runQ    <= 1'b0;
      end else begin
        runQ <= strobes[i].run;
        if (strobes[i].load) begin
          actPre <= shPre[i];
          actPer <= shPer[i];
          actHi  <= shHi[i];
        end
        if (!runQ) begin
          tickCnt <= '0;
          stepCnt <= '0;
        end else if (tickWrap) begin
          tickCnt <= '0;
          stepCnt <= (stepCnt == actPer) ? '0 : stepCnt + CNT_W'(1);
        end else begin
          tickCnt <= tickCnt + CNT_W'(1);
        end
      end
    end

    // a high-time past the divider saturates because stepCnt never exceeds actPer
    assign pwmOut[i]    = runQ && (stepCnt < actHi);
    assign periodEnd[i] = tickWrap && (stepCnt == actPer);
    assign runState[i]  = runQ;
    assign startVec[i]  = runQ && (tickCnt == '0) && (stepCnt == '0);
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chStrobe_t [NUM_CH-1:0]       strobes;
  logic [NUM_CH-1:0][CNT_W-1:0] shPre, shPer, shHi;
  logic [NUM_CH-1:0]            periodEnd, runVec, startVec, enVec, pendVec;

  pwm_quad_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .periodEnd(periodEnd), .runState(runVec),
    .strobes(strobes), .shPre(shPre), .shPer(shPer), .shHi(shHi),
    .enVec(enVec), .pendVec(pendVec)
  );

  pwm_quad_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shPre(shPre),
    .shPer(shPer), .shHi(shHi), .pwmOut(pwmOut), .periodEnd(periodEnd),
    .runState(runVec), .startVec(startVec)
  );
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NUM_CH = 4,
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [WORD_W-1:0] wordIdx,
  input logic [31:0]       rdData,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] enVec,
  input logic [NUM_CH-1:0] pendVec,
  input logic [NUM_CH-1:0] runVec,
  input logic [NUM_CH-1:0] startVec
);
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wordIdx >= WORD_W'(2 * NUM_CH)) |-> (rdData == 32'd0)); // R10

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (!enVec[g] && $past(!enVec[g])) |-> !pwmOut[g]); // R8

    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (runVec[g] && $past(runVec[g]) && !startVec[g] && $past(!pwmOut[g])) |-> !pwmOut[g]); // R4

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      $past(pendVec[g] && !runVec[g] && !wrEn) |-> !pendVec[g]); // R7
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NUM_CH(NUM_CH), .WORD_W(ADDR_W - 2)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wordIdx(addr[ADDR_W-1:2]),
  .rdData(rdData), .pwmOut(pwmOut), .enVec(enVec), .pendVec(pendVec),
  .runVec(runVec), .startVec(startVec)
);

// File: tb/pwm_quad_bench.sv
`timescale 1ns/1ps
module pwm_quad_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  pwmOut;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] UPD = 32'h4000_0000;

  always #2.5 clk = ~clk;

  pwm_quad u_pwm_quad (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
                       .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut));

  function automatic int expPeriod(int pre, int per);
    return (pre + 1) * (per + 1);
  endfunction

  function automatic int expHigh(int pre, int per, int hi);
    int h = (hi > per + 1) ? per + 1 : hi;
    return h * (pre + 1);
  endfunction

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitPend(int ch);
    logic [31:0] d;
    for (int n = 0; n < 400; n++) begin
      busRead(6'(8 * ch + 4), d);
      if (!d[30]) return;
      @(negedge clk);
    end
    checkEq("R7 pending never cleared", d[30], 1'b0);
  endtask

  task automatic configure(int ch, int pre, int per, int hi, logic [31:0] flags);
    busWrite(6'(8 * ch), {16'(hi), 16'(per)});
    busWrite(6'(8 * ch + 4), flags | 32'(16'(pre)));
  endtask

  // measure one channel's waveform against computed cycle and high lengths
  task automatic measure(string req, int ch, int p, int h);
    int highs = 0;
    logic prev, cur, found;
    if (h == 0 || h == p) begin
      for (int k = 0; k < 2 * p; k++) begin
        @(negedge clk);
        highs += int'(pwmOut[ch]);
      end
      checkEq(req, highs, 2 * h);
      return;
    end
    found = 1'b0;
    @(negedge clk);
    prev = pwmOut[ch];
    for (int k = 0; k < 4 * p + 20; k++) begin
      @(negedge clk);
      cur = pwmOut[ch];
      if (!prev && cur) begin found = 1'b1; break; end
      prev = cur;
    end
    checkEq({req, " cycle start"}, found, 1'b1);
    highs = 1;
    for (int k = 1; k < p; k++) begin
      @(negedge clk);
      highs += int'(pwmOut[ch]);
    end
    checkEq({req, " high time"}, highs, h);
    @(negedge clk);
    checkEq({req, " next cycle"}, pwmOut[ch], 1'b1);
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp0 [4];
    logic [31:0] exp1 [4];
    void'($urandom(32'd2024));

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkEq("R1 outputs", pwmOut, 4'h0);
    for (int a = 0; a < 8; a++) begin
      busRead(6'(4 * a), d);
      checkEq("R1 register", d, 32'h0);
    end

    // R2 register map readback
    for (int c = 0; c < 4; c++) begin
      exp0[c] = $urandom;
      exp1[c] = $urandom & 32'h3FFF_FFFF;
      busWrite(6'(8 * c), exp0[c]);
      busWrite(6'(8 * c + 4), exp1[c]);
      exp1[c] = exp1[c] & 32'h0000_FFFF;
    end
    for (int c = 0; c < 4; c++) begin
      busRead(6'(8 * c), d);     checkEq("R2 timing word", d, exp0[c]);
      busRead(6'(8 * c + 4), d); checkEq("R2 control word", d, exp1[c]);
    end

    // R10 unmapped offsets
    for (int a = 8; a < 16; a++) busWrite(6'(4 * a), $urandom | EN | UPD);
    for (int a = 8; a < 16; a++) begin
      busRead(6'(4 * a), d); checkEq("R10 unmapped read", d, 32'h0);
    end
    for (int c = 0; c < 4; c++) begin
      busRead(6'(8 * c), d);     checkEq("R10 timing untouched", d, exp0[c]);
      busRead(6'(8 * c + 4), d); checkEq("R10 control untouched", d, exp1[c]);
    end
    checkEq("R10 outputs idle", pwmOut, 4'h0);

    // R8 enable timing, then R3/R4 waveform
    busWrite(6'd0, {16'd2, 16'd3});
    busWrite(6'd4, EN | UPD | 32'd1);
    checkEq("R8 low cycle after enable write", pwmOut[0], 1'b0);
    @(negedge clk);
    checkEq("R8 starts high", pwmOut[0], 1'b1);
    busRead(6'd4, d);
    checkEq("R2 R7 enabled control word", d, EN | 32'd1);
    measure("R3 R4 ch0", 0, expPeriod(1, 3), expHigh(1, 3, 2));

    // R9 independent channels, R5 saturation on ch3
    configure(1, 0, 4, 1, EN | UPD);
    configure(2, 2, 1, 1, EN | UPD);
    configure(3, 0, 2, 5, EN | UPD);
    for (int c = 1; c < 4; c++) waitPend(c);
    measure("R9 ch1", 1, expPeriod(0, 4), expHigh(0, 4, 1));
    measure("R9 ch2", 2, expPeriod(2, 1), expHigh(2, 1, 1));
    measure("R5 R9 ch3 saturated", 3, expPeriod(0, 2), expHigh(0, 2, 5));
    measure("R9 ch0 unchanged", 0, expPeriod(1, 3), expHigh(1, 3, 2));

    // R6 held until update and cycle end
    busWrite(6'd8, {16'd3, 16'd5});
    measure("R6 old timing kept", 1, expPeriod(0, 4), expHigh(0, 4, 1));
    busRead(6'd8, d);
    checkEq("R6 holding register visible", d, {16'd3, 16'd5});
    busWrite(6'd12, EN | UPD);
    busRead(6'd12, d);
    checkEq("R7 update pending", d, EN | UPD);
    waitPend(1);
    measure("R6 new timing", 1, expPeriod(0, 5), expHigh(0, 5, 3));

    // R5 zero high-time
    configure(2, 2, 1, 0, EN | UPD);
    waitPend(2);
    measure("R5 zero high", 2, expPeriod(2, 1), 0);

    // R8 disable, R7 copy on stopped channel
    busWrite(6'd28, 32'h0);
    @(negedge clk);
    checkEq("R8 disabled low", pwmOut[3], 1'b0);
    busWrite(6'd24, {16'd1, 16'd1});
    busWrite(6'd28, UPD);
    busRead(6'd28, d);
    checkEq("R7 pending on stopped channel", d, UPD);
    @(negedge clk);
    busRead(6'd28, d);
    checkEq("R7 stopped copy done", d, 32'h0);
    busWrite(6'd28, EN);
    measure("R7 values active after enable", 3, expPeriod(0, 1), expHigh(0, 1, 1));

    // R3 R4 R5 random configurations
    for (int n = 0; n < 10; n++) begin
      int ch  = int'($urandom % 4);
      int pre = int'($urandom % 4);
      int per = int'($urandom % 6);
      int hi  = int'($urandom % (per + 3));
      configure(ch, pre, per, hi, EN | UPD);
      waitPend(ch);
      measure("R3 R4 R5 random", ch, expPeriod(pre, per), expHigh(pre, per, hi));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule